// File: doc/BRIEF.md
# Transmit Link Sequencer with Diagnostic Patterns

This block sequences the link-layer characters that a multi-lane serial converter transmitter sends. Each lane gets one byte and a control flag per character clock, and an 8b/10b encoder further down the path turns them into line symbols. After reset, and whenever the receiver pulls its active-low sync request low, every lane sends the comma character K28.5. Once the request is released, the block counts multiframe boundary ticks. On the tick that software selects, it begins a four-multiframe initial lane alignment sequence, and then it forwards user data.

A 3-bit test field can replace the normal output with a fixed data character, a stream of commas, an endlessly repeating alignment sequence or a short pseudo-random pattern. A separate forced-resync bit sends commas and holds the link in synchronization until software clears it. Every lane carries the same character except in the data phase, where each lane forwards its own byte. Outputs are combinational from the state registers and the current inputs, so a character belongs to the cycle in which it is presented.

Top module: `ltx_seq`

## Requirements
- R1: While reset is asserted, and in the first character after it ends with the sync request held low and mode 000, every lane outputs byte 0xBC with K=1 (K28.5).
- R2: In normal mode with no forced resync, each character that follows a cycle in which sync_ni was sampled low is K28.5 on every lane.
- R3: A tick counts when lmfc_tick_i is high at a clock edge while sync_ni is high, no forced resync is active and the link is synchronizing. With release_i = N, the first alignment character appears in the cycle right after the (N+1)-th such tick. Before that, K28.5 is sent.
- R4: The alignment sequence has 4*MF_CHARS characters with index i. Position p = i mod MF_CHARS is 0x1C K=1 at p=0, 0x7C K=1 at p=MF_CHARS-1, and 0x9C K=1 at p=1 of the second multiframe. Every other position is byte i with K=0.
- R5: After the last alignment character, in normal mode, lane n outputs data_i[8n+7:8n] with K=0, in the same cycle that the data is presented.
- R6: Sampling sync_ni low during the alignment or data phase returns the link to synchronization at the next edge, with K28.5 from the following character.
- R7: While sync_req_i is high, every lane outputs K28.5 whatever the mode. After it clears, the link is in synchronization and the tick count of R3 starts from zero.
- R8: Mode 001 outputs 0xB5 (D21.5) with K=0 on every lane.
- R9: Mode 010 outputs K28.5 on every lane.
- R10: Mode 011 outputs the R4 sequence on every lane without stopping. It starts at index 0 in the first cycle that the mode differs from the previous cycle, and wraps after index 4*MF_CHARS-1.
- R11: Mode 100 outputs a 12-character pattern with K=0 that starts at character 0 on mode entry and repeats. It comes from a 7-bit register seeded 0x7F and advanced 8 steps per character. Each step computes b = s[6]^s[5] and sets s = {s[5:0], b}. The 8 new bits form the byte, with the first bit generated at the MSB.
- R12: Modes 101, 110 and 111 behave exactly as mode 000.
- R13: In every test mode, all lanes carry the same character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lmfc_tick_i | input | 1 | One-cycle pulse; the character after it starts a multiframe |
| sync_ni | input | 1 | Active-low resynchronization request from the receiver |
| sync_req_i | input | 1 | Forced resync: send commas and hold synchronization |
| mode_i | input | 3 | Output pattern select |
| release_i | input | REL_W | Selects the multiframe tick that starts alignment |
| data_i | input | 8*LANES | User bytes, lane n at bits 8n+7:8n |
| char_o | output | 8*LANES | Character byte per lane |
| k_o | output | LANES | Control-character flag per lane |

## Verification
A wrong phase state shows up at the ports in the same character. If the block stays in synchronization too long, it sends K28.5 where the alignment start character 0x1C is expected. If it leaves synchronization too early, the alignment start arrives one multiframe early. An alignment index that is off by one moves the 0x9C and 0x7C markers and changes the filler bytes at once. A pattern counter or random-sequence register that fails to restart on mode entry gives a wrong first character in the test mode. A missed wrap gives a wrong character 32 or 12 characters later.

// File: rtl/ltx_pkg.sv
package ltx_pkg;
  localparam logic [7:0] CH_K28_5 = 8'hBC;
  localparam logic [7:0] CH_K28_0 = 8'h1C;
  localparam logic [7:0] CH_K28_3 = 8'h7C;
  localparam logic [7:0] CH_K28_4 = 8'h9C;
  localparam logic [7:0] CH_D21_5 = 8'hB5;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_ILA  = 2'd1,
    ST_DATA = 2'd2
  } link_st_e;

  typedef enum logic [2:0] {
    MD_NORM = 3'd0,
    MD_D215 = 3'd1,
    MD_K285 = 3'd2,
    MD_ILA  = 3'd3,
    MD_PRBS = 3'd4
  } tmode_e;

  typedef struct packed {
    logic       k;
    logic [7:0] b;
  } sym_t;
endpackage

// File: rtl/ltx_rel_gate.sv
module ltx_rel_gate #(
  parameter int REL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [REL_W-1:0] release_i,
  output logic             fire_o
);
  logic [REL_W-1:0] cnt_q;

  assign fire_o = !clear_i && tick_i && (cnt_q == release_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clear_i)                         cnt_q <= '0;
    else if (tick_i && cnt_q != release_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ltx_ila_sym.sv
module ltx_ila_sym
  import ltx_pkg::*;
#(
  parameter int MF_CHARS = 8,
  parameter int IDX_W    = $clog2(MF_CHARS) + 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output sym_t             sym_o
);
  localparam int               POS_W    = $clog2(MF_CHARS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(MF_CHARS - 1);

  logic [POS_W-1:0] pos;
  logic [1:0]       mf;

  assign pos = idx_i[POS_W-1:0];
  assign mf  = idx_i[IDX_W-1:POS_W];

  always_comb begin
    sym_o = '{k: 1'b0, b: 8'(idx_i)};
    if (pos == '0)                       sym_o = '{k: 1'b1, b: CH_K28_0};
    else if (pos == POS_LAST)            sym_o = '{k: 1'b1, b: CH_K28_3};
    else if (mf == 2'd1 && pos == POS_W'(1)) sym_o = '{k: 1'b1, b: CH_K28_4};
  end
endmodule

// File: rtl/ltx_prbs.sv
module ltx_prbs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       advance_i,
  output logic [7:0] byte_o
);
  localparam logic [6:0] SEED = 7'h7F;

  logic [6:0] lfsr_q, cur, nxt;
  logic       nb;

  always_comb begin
    cur    = restart_i ? SEED : lfsr_q;
    nxt    = cur;
    byte_o = '0;
    nb     = 1'b0;
    for (int b = 0; b < 8; b++) begin
      nb     = nxt[6] ^ nxt[5];
      byte_o = {byte_o[6:0], nb};
      nxt    = {nxt[5:0], nb};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lfsr_q <= SEED;
    else if (advance_i) lfsr_q <= nxt;
  end
endmodule

// File: rtl/ltx_seq.sv
module ltx_seq
  import ltx_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int MF_CHARS = 8,
  parameter int REL_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lmfc_tick_i,
  input  logic               sync_ni,
  input  logic               sync_req_i,
  input  logic [2:0]         mode_i,
  input  logic [REL_W-1:0]   release_i,
  input  logic [8*LANES-1:0] data_i,
  output logic [8*LANES-1:0] char_o,
  output logic [LANES-1:0]   k_o
);
  localparam int POS_W    = $clog2(MF_CHARS);
  localparam int ILA_W    = POS_W + 2;
  localparam int ILA_LEN  = 4 * MF_CHARS;
  localparam int PRBS_LEN = 12;
  localparam int PAT_W    = (ILA_W > 4) ? ILA_W : 4;

  link_st_e         st_q;
  logic [ILA_W-1:0] ila_idx_q;
  logic             fire, gate_clr;
  logic [2:0]       mode_q;
  logic             mode_chg;
  logic [PAT_W-1:0] pat_q, pat_eff, pat_lim, pat_nxt;
  sym_t             sym_link, sym_test, com;
  logic [7:0]       prbs_byte;
  logic             use_data;

  assign gate_clr = sync_req_i || !sync_ni || (st_q != ST_CGS);

  ltx_rel_gate #(.REL_W(REL_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (gate_clr),
    .tick_i    (lmfc_tick_i),
    .release_i (release_i),
    .fire_o    (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CGS;
      ila_idx_q <= '0;
    end else if (sync_req_i || !sync_ni) begin
      st_q      <= ST_CGS;
      ila_idx_q <= '0;
    end else begin
      case (st_q)
        ST_CGS: if (fire) begin
          st_q      <= ST_ILA;
          ila_idx_q <= '0;
        end
        ST_ILA: begin
          if (ila_idx_q == ILA_W'(ILA_LEN - 1)) st_q <= ST_DATA;
          ila_idx_q <= ila_idx_q + 1'b1;
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

  // pattern index restarts whenever the mode field changes
  assign mode_chg = (mode_i != mode_q);
  assign pat_eff  = mode_chg ? '0 : pat_q;
  assign pat_lim  = (mode_i == MD_ILA) ? PAT_W'(ILA_LEN - 1) : PAT_W'(PRBS_LEN - 1);
  assign pat_nxt  = (pat_eff >= pat_lim) ? '0 : pat_eff + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 3'd0;
      pat_q  <= '0;
    end else begin
      mode_q <= mode_i;
      pat_q  <= pat_nxt;
    end
  end

  ltx_ila_sym #(.MF_CHARS(MF_CHARS), .IDX_W(ILA_W)) u_ila_link (
    .idx_i (ila_idx_q),
    .sym_o (sym_link)
  );

  ltx_ila_sym #(.MF_CHARS(MF_CHARS), .IDX_W(ILA_W)) u_ila_test (
    .idx_i (pat_eff[ILA_W-1:0]),
    .sym_o (sym_test)
  );

  ltx_prbs u_prbs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (pat_eff == '0),
    .advance_i (mode_i == MD_PRBS),
    .byte_o    (prbs_byte)
  );

  always_comb begin
    use_data = 1'b0;
    com      = '{k: 1'b1, b: CH_K28_5};
    if (!sync_req_i) begin
      case (mode_i)
        MD_D215: com = '{k: 1'b0, b: CH_D21_5};
        MD_K285: com = '{k: 1'b1, b: CH_K28_5};
        MD_ILA:  com = sym_test;
        MD_PRBS: com = '{k: 1'b0, b: prbs_byte};
        default: begin
          case (st_q)
            ST_ILA:  com = sym_link;
            ST_DATA: use_data = 1'b1;
            default: com = '{k: 1'b1, b: CH_K28_5};
          endcase
        end
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign char_o[8*g +: 8] = use_data ? data_i[8*g +: 8] : com.b;
    assign k_o[g]           = use_data ? 1'b0 : com.k;
  end
endmodule

// File: rtl/ltx_seq_chk.sv
module ltx_seq_chk
  import ltx_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lmfc_tick_i,
  input logic               sync_ni,
  input logic               sync_req_i,
  input logic [2:0]         mode_i,
  input logic [8*LANES-1:0] char_o,
  input logic [LANES-1:0]   k_o,
  input link_st_e           st_i
);
  localparam logic [8*LANES-1:0] ALL_K285 = {LANES{CH_K28_5}};
  localparam logic [8*LANES-1:0] ALL_D215 = {LANES{CH_D21_5}};

  assert_req_k285_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_i |-> (char_o == ALL_K285 && k_o == '1));

  assert_d215_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_req_i && mode_i == 3'd1) |-> (char_o == ALL_D215 && k_o == '0));

  assert_k285_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_req_i && mode_i == 3'd2) |-> (char_o == ALL_K285 && k_o == '1));

  assert_cgs_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_req_i && mode_i == 3'd0 && $past(!sync_ni)) |-> (char_o == ALL_K285 && k_o == '1));

  assert_ila_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ILA && $past(st_i) == ST_CGS) |-> $past(lmfc_tick_i && sync_ni && !sync_req_i));

  assert_ila_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ILA && $past(st_i) == ST_CGS && !sync_req_i && mode_i == 3'd0)
      |-> (char_o[7:0] == CH_K28_0 && k_o == '1));

  assert_resync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_i != ST_CGS) && $past(!sync_ni)) |-> (st_i == ST_CGS));
endmodule

bind ltx_seq ltx_seq_chk #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lmfc_tick_i (lmfc_tick_i),
  .sync_ni     (sync_ni),
  .sync_req_i  (sync_req_i),
  .mode_i      (mode_i),
  .char_o      (char_o),
  .k_o         (k_o),
  .st_i        (st_q)
);

// File: tb/ltx_seq_tb_top.sv
`timescale 1ns/1ps
module ltx_seq_tb_top;
  localparam int LANES = 2;
  localparam int MF    = 8;
  localparam int ILEN  = 4 * MF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lmfc_tick_i = 1'b0;
  logic        sync_ni = 1'b0;
  logic        sync_req_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [1:0]  release_i = 2'd0;
  logic [15:0] data_i = {8'hA5, 8'h5A};
  logic [15:0] char_o;
  logic [1:0]  k_o;

  int n_chk = 0, n_err = 0, cyc_n = 0;
  logic [7:0] prbs_exp [12];

  always #2 clk_i = ~clk_i;

  ltx_seq #(.LANES(LANES), .MF_CHARS(MF), .REL_W(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lmfc_tick_i(lmfc_tick_i), .sync_ni(sync_ni),
    .sync_req_i(sync_req_i), .mode_i(mode_i), .release_i(release_i),
    .data_i(data_i), .char_o(char_o), .k_o(k_o)
  );

  // {mode, lane0, lane1, k}
  localparam logic [19:0] VEC [6] = '{
    {3'd0, 8'h5A, 8'hA5, 1'b0},
    {3'd1, 8'hB5, 8'hB5, 1'b0},
    {3'd2, 8'hBC, 8'hBC, 1'b1},
    {3'd5, 8'h5A, 8'hA5, 1'b0},
    {3'd6, 8'h5A, 8'hA5, 1'b0},
    {3'd7, 8'h5A, 8'hA5, 1'b0}
  };

  function automatic logic [8:0] ila_exp(int i);
    int p = i % MF;
    int m = i / MF;
    if (p == 0)                return {1'b1, 8'h1C};
    else if (p == MF - 1)      return {1'b1, 8'h7C};
    else if (m == 1 && p == 1) return {1'b1, 8'h9C};
    else                       return {1'b0, 8'(i)};
  endfunction

  task automatic chk(string tag, logic [7:0] e0, logic [7:0] e1, logic [1:0] ek);
    n_chk++;
    if (char_o !== {e1, e0} || k_o !== ek) begin
      n_err++;
      $display("FAIL %s: got char=%h k=%b, expected char=%h k=%b", tag, char_o, k_o, {e1, e0}, ek);
    end
  endtask

  // inputs change 1 ns after the edge, outputs are sampled 2 ns after it
  task automatic cyc(logic [2:0] m, logic rq, logic sn);
    @(posedge clk_i);
    #1;
    cyc_n++;
    lmfc_tick_i = (cyc_n % MF == 0);
    mode_i = m; sync_req_i = rq; sync_ni = sn;
    #1;
  endtask

  task automatic run_link(int rel);
    int   ticks = 0;
    logic started = 1'b0;
    logic [8:0] e;
    release_i = 2'(rel);
    for (int c = 0; c < 200 && !started; c++) begin
      cyc(3'd0, 1'b0, 1'b1);
      if (ticks == rel + 1) begin
        chk("R3 alignment start", 8'h1C, 8'h1C, 2'b11);
        started = 1'b1;
      end else begin
        chk("R3 comma before release", 8'hBC, 8'hBC, 2'b11);
        if (lmfc_tick_i) ticks++;
      end
    end
    for (int i = 1; i < ILEN; i++) begin
      cyc(3'd0, 1'b0, 1'b1);
      e = ila_exp(i);
      chk("R4 alignment character", e[7:0], e[7:0], {2{e[8]}});
    end
    cyc(3'd0, 1'b0, 1'b1);
    chk("R5 first data", 8'h5A, 8'hA5, 2'b00);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [6:0] s;
    logic [7:0] by;
    logic       nb;
    logic [8:0] e;
    s = 7'h7F;
    for (int c = 0; c < 12; c++) begin
      by = '0;
      for (int b = 0; b < 8; b++) begin
        nb = s[6] ^ s[5];
        by = {by[6:0], nb};
        s  = {s[5:0], nb};
      end
      prbs_exp[c] = by;
    end

    #1;
    chk("R1 during reset", 8'hBC, 8'hBC, 2'b11);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc(3'd0, 1'b0, 1'b0);
    chk("R1 after reset", 8'hBC, 8'hBC, 2'b11);
    for (int i = 0; i < 20; i++) begin
      cyc(3'd0, 1'b0, 1'b0);
      chk("R2 hold while sync low", 8'hBC, 8'hBC, 2'b11);
    end

    run_link(2);

    // static pattern table, R8 R9 R12 R13 R5
    for (int v = 0; v < 6; v++) begin
      cyc(VEC[v][19:17], 1'b0, 1'b1);
      chk(VEC[v][19:17] >= 3'd5 ? "R12 invalid mode" :
          VEC[v][19:17] == 3'd1 ? "R8 D21.5" :
          VEC[v][19:17] == 3'd2 ? "R9 K28.5" : "R5 data",
          VEC[v][16:9], VEC[v][8:1], {2{VEC[v][0]}});
    end

    // R10 continuous alignment pattern, wraps once
    for (int i = 0; i < ILEN + 8; i++) begin
      cyc(3'd3, 1'b0, 1'b1);
      e = ila_exp(i % ILEN);
      chk("R10 R13 looped alignment", e[7:0], e[7:0], {2{e[8]}});
    end
    cyc(3'd0, 1'b0, 1'b1);
    chk("R5 data after test mode", 8'h5A, 8'hA5, 2'b00);

    // R11 pseudo-random pattern, two periods
    for (int i = 0; i < 24; i++) begin
      cyc(3'd4, 1'b0, 1'b1);
      chk("R11 R13 random pattern", prbs_exp[i % 12], prbs_exp[i % 12], 2'b00);
    end
    // re-entry restarts at character 0
    cyc(3'd0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(3'd4, 1'b0, 1'b1);
      chk("R11 restart on entry", prbs_exp[i], prbs_exp[i], 2'b00);
    end

    // R6 sync drop in data phase
    cyc(3'd0, 1'b0, 1'b0);
    chk("R6 same cycle still data", 8'h5A, 8'hA5, 2'b00);
    cyc(3'd0, 1'b0, 1'b0);
    chk("R6 comma after drop", 8'hBC, 8'hBC, 2'b11);
    run_link(0);

    // R6 sync drop during alignment
    cyc(3'd0, 1'b0, 1'b0);
    cyc(3'd0, 1'b0, 1'b0);
    release_i = 2'd0;
    begin
      int   ticks = 0;
      logic done = 1'b0;
      for (int c = 0; c < 100 && !done; c++) begin
        cyc(3'd0, 1'b0, 1'b1);
        if (ticks == 1) done = 1'b1;
        else if (lmfc_tick_i) ticks++;
      end
    end
    chk("R6 alignment reached", 8'h1C, 8'h1C, 2'b11);
    cyc(3'd0, 1'b0, 1'b0);
    cyc(3'd0, 1'b0, 1'b0);
    chk("R6 comma after drop in alignment", 8'hBC, 8'hBC, 2'b11);

    run_link(3);

    // R7 forced resync overrides test mode
    for (int i = 0; i < 4; i++) begin
      cyc(3'd1, 1'b1, 1'b1);
      chk("R7 forced comma", 8'hBC, 8'hBC, 2'b11);
    end
    cyc(3'd4, 1'b1, 1'b1);
    chk("R7 forced comma over random mode", 8'hBC, 8'hBC, 2'b11);
    run_link(1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule